// File: doc/BRIEF.md
# Pad Function Selector

This block decides which on-chip peripheral function drives each external terminal. Software programs a small bank of 32-bit selection registers over a word-addressed memory-mapped bus. Each byte of a selection register belongs to one terminal, and the single set bit inside that byte names the function that owns the terminal. For every terminal a dedicated multiplexer then forwards the complete buffer-control bundle of the chosen function to the pad: the data value, the output enable, the standard-buffer enable and the low-power select. All four pad controls leave the block through flops.

The selection registers are protected in two ways. Only bus writes flagged as privileged are accepted, and the selection registers are writable only after a two-step unlock: a first key must be written to one unlock register and a second key to another. A rejected write leaves every register as it was and sets a sticky error flag, which software clears by writing 1 to it. Reads are open to any mode and return data one cycle after the request.

Top module: `pinmux_ctrl`

## Requirements
- R1: Terminal t is controlled by byte t mod 4 (bits 8*(t mod 4)+7 down to 8*(t mod 4)) of the selection register at word address t/4; word addresses 0 to ceil(NUM_TERM/4)-1 hold selection registers.
- R2: When the byte of terminal t has exactly one set bit f, the pad outputs pad_dout, pad_oe, pad_sben and pad_lpm of terminal t equal fn_dout, fn_oe, fn_sben and fn_lpm at bit index t*NUM_FUNC+f, sampled at the previous clock edge; the pads are registered, so a selection change accepted at edge E is seen on the pads after edge E+1.
- R3: After reset every byte of an existing terminal reads with only bit 0 set, every pad follows function 0, the registers are locked and the error flag is 0.
- R4: When the byte of a terminal holds no set bit or more than one set bit, that terminal follows function 0.
- R5: Bits at positions NUM_FUNC and above in each byte, and every byte whose terminal index is NUM_TERM or more, read as 0 and keep 0 whatever is written.
- R6: A read (bus_sel=1, bus_wr=0) is served whatever bus_priv is, and bus_rdata carries the addressed value from the clock edge that accepts the read until the next read.
- R7: A write with bus_priv=0 to any address changes no register and no unlock state, and sets the error flag.
- R8: The unlock register pair sits at word address 12 (first key 32'hA5C3_1E70) and 13 (second key 32'h5B29_D4C6); writing the first key to 12 and then the second key to 13 unlocks; any other value written to either address locks again; a privileged write to a selection register while locked changes nothing and sets the error flag.
- R9: The status register at word address 14 reads error flag in bit 0 and unlock state in bit 1; the error flag stays set until a privileged write to address 14 with bit 0 equal to 1, and a write with bit 0 equal to 0 leaves it set.
- R10: The unlock registers and all unmapped addresses read as 0, and a privileged write to an unmapped address neither changes state nor sets the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_priv | input | 1 | Access is made in privileged mode |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| err_flag | output | 1 | Sticky protection-violation flag |
| fn_dout | input | NUM_TERM*NUM_FUNC | Output value offered by each function, index t*NUM_FUNC+f |
| fn_oe | input | NUM_TERM*NUM_FUNC | Output enable offered by each function |
| fn_sben | input | NUM_TERM*NUM_FUNC | Standard-buffer enable offered by each function |
| fn_lpm | input | NUM_TERM*NUM_FUNC | Low-power select offered by each function |
| pad_dout | output | NUM_TERM | Output value to each pad |
| pad_oe | output | NUM_TERM | Output enable to each pad |
| pad_sben | output | NUM_TERM | Standard-buffer enable to each pad |
| pad_lpm | output | NUM_TERM | Low-power select to each pad |

## Verification
A selection write and a change of the function-side inputs can land in the same cycle, and the registered pad path must then show the new input values under the old selection for one cycle before switching to the new selection. The bench drives both in one cycle and compares the pads after each of the next two edges against a model that applies the two changes with their separate latencies. A second overlap, a rejected write arriving while the error flag is already set, is judged by reading the status register afterwards.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

  typedef struct packed {
    logic dout;
    logic oe;
    logic sben;
    logic lpm;
  } pad_ctl_t;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_ARMED  = 2'd1,
    KS_OPEN   = 2'd2
  } kick_st_e;

  localparam logic [31:0] KEY_FIRST  = 32'hA5C3_1E70;
  localparam logic [31:0] KEY_SECOND = 32'h5B29_D4C6;

  localparam int unsigned ADDR_KICK0 = 12;
  localparam int unsigned ADDR_KICK1 = 13;
  localparam int unsigned ADDR_STAT  = 14;

  // Writable bits of selection word r
  function automatic logic [31:0] sel_mask(int nt, int nf, int r);
    logic [31:0] m;
    m = '0;
    for (int b = 0; b < 4; b++)
      if (r * 4 + b < nt)
        for (int f = 0; f < nf; f++) m[b*8+f] = 1'b1;
    return m;
  endfunction

  // Reset value of selection word r: default function in every used lane
  function automatic logic [31:0] sel_reset(int nt, int r);
    logic [31:0] v;
    v = '0;
    for (int b = 0; b < 4; b++)
      if (r * 4 + b < nt) v[b*8] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/pinmux_kick.sv
module pinmux_kick
  import pinmux_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        kick_wr0,
  input  logic        kick_wr1,
  input  logic [31:0] wdata,
  output logic        unlocked
);

  kick_st_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= KS_LOCKED;
    end else if (kick_wr0) begin
      if (wdata != KEY_FIRST)      st_q <= KS_LOCKED;
      else if (st_q == KS_LOCKED)  st_q <= KS_ARMED;
    end else if (kick_wr1) begin
      if (wdata == KEY_SECOND && st_q != KS_LOCKED) st_q <= KS_OPEN;
      else                                         st_q <= KS_LOCKED;
    end
  end

  assign unlocked = (st_q == KS_OPEN);

endmodule

// File: rtl/pinmux_regs.sv
module pinmux_regs
  import pinmux_pkg::*;
#(
  parameter int NUM_TERM = 6,
  parameter int NUM_FUNC = 4,
  parameter int ADDR_W   = 4,
  localparam int NREG    = (NUM_TERM + 3) / 4
)(
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic                bus_priv,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  input  logic                unlocked,
  output logic                kick_wr0,
  output logic                kick_wr1,
  output logic [NREG*32-1:0]  cfg_flat,
  output logic [31:0]         bus_rdata,
  output logic                err_flag
);

  logic wr_ok, wr_unpriv, ctrl_hit, wr_locked, err_clr;
  logic [31:0] rd_mux;

  assign wr_ok     = bus_sel & bus_wr & bus_priv;
  assign wr_unpriv = bus_sel & bus_wr & ~bus_priv;
  assign ctrl_hit  = (bus_addr < ADDR_W'(NREG));
  assign wr_locked = wr_ok & ctrl_hit & ~unlocked;
  assign kick_wr0  = wr_ok & (bus_addr == ADDR_W'(ADDR_KICK0));
  assign kick_wr1  = wr_ok & (bus_addr == ADDR_W'(ADDR_KICK1));
  assign err_clr   = wr_ok & (bus_addr == ADDR_W'(ADDR_STAT)) & bus_wdata[0];

  genvar r;
  generate
    for (r = 0; r < NREG; r++) begin : g_word
      localparam logic [31:0] MASK = sel_mask(NUM_TERM, NUM_FUNC, r);
      localparam logic [31:0] RSTV = sel_reset(NUM_TERM, r);
      logic [31:0] word_q;
      always_ff @(posedge clk) begin
        if (rst)
          word_q <= RSTV;
        else if (wr_ok && unlocked && bus_addr == ADDR_W'(r))
          word_q <= bus_wdata & MASK;
      end
      assign cfg_flat[r*32 +: 32] = word_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                       err_flag <= 1'b0;
    else if (wr_unpriv || wr_locked) err_flag <= 1'b1;
    else if (err_clr)              err_flag <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++)
      if (bus_addr == ADDR_W'(i)) rd_mux = cfg_flat[i*32 +: 32];
    if (bus_addr == ADDR_W'(ADDR_STAT)) rd_mux = {30'd0, unlocked, err_flag};
  end

  always_ff @(posedge clk) begin
    if (rst)                    bus_rdata <= '0;
    else if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/pinmux_lane.sv
module pinmux_lane
  import pinmux_pkg::*;
#(
  parameter int NUM_FUNC = 4,
  localparam int IW      = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1
)(
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_FUNC-1:0] sel,
  input  pad_ctl_t            fn [NUM_FUNC],
  output pad_ctl_t            pad_q
);

  logic [IW-1:0] idx, pick;

  always_comb begin
    idx = '0;
    for (int f = 0; f < NUM_FUNC; f++)
      if (sel[f]) idx = IW'(f);
    // anything other than a single set bit falls back to the default source
    pick = ($countones(sel) == 1) ? idx : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) pad_q <= '0;
    else     pad_q <= fn[pick];
  end

endmodule

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl
  import pinmux_pkg::*;
#(
  parameter int NUM_TERM = 6,
  parameter int NUM_FUNC = 4,
  parameter int ADDR_W   = 4,
  localparam int NREG    = (NUM_TERM + 3) / 4,
  localparam int NSRC    = NUM_TERM * NUM_FUNC
)(
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic                bus_priv,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                err_flag,
  input  logic [NSRC-1:0]     fn_dout,
  input  logic [NSRC-1:0]     fn_oe,
  input  logic [NSRC-1:0]     fn_sben,
  input  logic [NSRC-1:0]     fn_lpm,
  output logic [NUM_TERM-1:0] pad_dout,
  output logic [NUM_TERM-1:0] pad_oe,
  output logic [NUM_TERM-1:0] pad_sben,
  output logic [NUM_TERM-1:0] pad_lpm
);

  logic               kick_wr0, kick_wr1, unlocked;
  logic [NREG*32-1:0] cfg_flat;

  pinmux_kick u_kick (
    .clk      (clk),
    .rst      (rst),
    .kick_wr0 (kick_wr0),
    .kick_wr1 (kick_wr1),
    .wdata    (bus_wdata),
    .unlocked (unlocked)
  );

  pinmux_regs #(
    .NUM_TERM (NUM_TERM),
    .NUM_FUNC (NUM_FUNC),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_priv  (bus_priv),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .unlocked  (unlocked),
    .kick_wr0  (kick_wr0),
    .kick_wr1  (kick_wr1),
    .cfg_flat  (cfg_flat),
    .bus_rdata (bus_rdata),
    .err_flag  (err_flag)
  );

  genvar t;
  generate
    for (t = 0; t < NUM_TERM; t++) begin : g_term
      pad_ctl_t fn_set [NUM_FUNC];
      pad_ctl_t pad_w;

      always_comb begin
        for (int f = 0; f < NUM_FUNC; f++) begin
          fn_set[f].dout = fn_dout[t*NUM_FUNC+f];
          fn_set[f].oe   = fn_oe[t*NUM_FUNC+f];
          fn_set[f].sben = fn_sben[t*NUM_FUNC+f];
          fn_set[f].lpm  = fn_lpm[t*NUM_FUNC+f];
        end
      end

      pinmux_lane #(.NUM_FUNC(NUM_FUNC)) u_lane (
        .clk   (clk),
        .rst   (rst),
        .sel   (cfg_flat[t*8 +: NUM_FUNC]),
        .fn    (fn_set),
        .pad_q (pad_w)
      );

      assign pad_dout[t] = pad_w.dout;
      assign pad_oe[t]   = pad_w.oe;
      assign pad_sben[t] = pad_w.sben;
      assign pad_lpm[t]  = pad_w.lpm;
    end
  endgenerate

endmodule

// File: rtl/pinmux_chk.sv
module pinmux_chk
  import pinmux_pkg::*;
#(
  parameter int NUM_TERM = 6,
  parameter int NUM_FUNC = 4,
  parameter int ADDR_W   = 4,
  localparam int NREG    = (NUM_TERM + 3) / 4
)(
  input logic               clk,
  input logic               rst,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic               bus_priv,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_wdata,
  input logic               err_flag,
  input logic               unlocked,
  input logic [NREG*32-1:0] cfg_flat
);

  function automatic logic [NREG*32-1:0] all_mask();
    logic [NREG*32-1:0] m;
    for (int r = 0; r < NREG; r++) m[r*32 +: 32] = sel_mask(NUM_TERM, NUM_FUNC, r);
    return m;
  endfunction

  localparam logic [NREG*32-1:0] USED = all_mask();

  logic wr_unpriv, wr_lock_ctrl, err_clr, kick1_ok;
  assign wr_unpriv    = bus_sel && bus_wr && !bus_priv;
  assign wr_lock_ctrl = bus_sel && bus_wr && bus_priv && !unlocked && (bus_addr < ADDR_W'(NREG));
  assign err_clr      = bus_sel && bus_wr && bus_priv && (bus_addr == ADDR_W'(ADDR_STAT)) && bus_wdata[0];
  assign kick1_ok     = bus_sel && bus_wr && bus_priv && (bus_addr == ADDR_W'(ADDR_KICK1))
                        && (bus_wdata == KEY_SECOND);

  AST_UNPRIV_HOLDS: assert property (@(posedge clk) disable iff (rst)
    wr_unpriv |=> $stable(cfg_flat) && $stable(unlocked)); // R7
  AST_UNPRIV_FLAGS: assert property (@(posedge clk) disable iff (rst)
    wr_unpriv |=> err_flag); // R7
  AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    wr_lock_ctrl |=> $stable(cfg_flat) && err_flag); // R8
  AST_UNLOCK_SEQ: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(kick1_ok)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !err_clr) |=> err_flag); // R9
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cfg_flat & ~USED) == '0); // R5

endmodule

bind pinmux_ctrl pinmux_chk #(
  .NUM_TERM (NUM_TERM),
  .NUM_FUNC (NUM_FUNC),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_priv  (bus_priv),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .err_flag  (err_flag),
  .unlocked  (unlocked),
  .cfg_flat  (cfg_flat)
);

// File: tb/sim_pinmux_ctrl.sv
module sim_pinmux_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NT   = 6;
  localparam int NF   = 4;
  localparam int AW   = 4;
  localparam int NREG = (NT + 3) / 4;
  localparam int NS   = NT * NF;
  localparam logic [31:0] K0 = 32'hA5C3_1E70;
  localparam logic [31:0] K1 = 32'h5B29_D4C6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0, bus_priv = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic err_flag;
  logic [NS-1:0] fn_dout = '0, fn_oe = '0, fn_sben = '0, fn_lpm = '0;
  logic [NT-1:0] pad_dout, pad_oe, pad_sben, pad_lpm;

  int nvec = 0;
  int nbad = 0;
  logic [31:0] exp_cfg [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  pinmux_ctrl #(.NUM_TERM(NT), .NUM_FUNC(NF), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_priv(bus_priv),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .err_flag(err_flag),
    .fn_dout(fn_dout), .fn_oe(fn_oe), .fn_sben(fn_sben), .fn_lpm(fn_lpm),
    .pad_dout(pad_dout), .pad_oe(pad_oe), .pad_sben(pad_sben), .pad_lpm(pad_lpm)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input int a, input logic [31:0] d, input logic p);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_priv = p; bus_addr = AW'(a); bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_priv = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_priv = 1'b0; bus_addr = AW'(a);
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] lane_mask(int r);
    logic [31:0] m = '0;
    for (int b = 0; b < 4; b++)
      if (r * 4 + b < NT) m[b*8 +: NF] = '1;
    return m;
  endfunction

  // expected {dout,oe,sben,lpm} of terminal t for a selection byte
  function automatic logic [3:0] exp_pad(int t, logic [7:0] byt);
    int f = 0;
    int ones = 0;
    for (int i = 0; i < NF; i++) if (byt[i]) begin ones++; f = i; end
    if (ones != 1) f = 0;
    return {fn_dout[t*NF+f], fn_oe[t*NF+f], fn_sben[t*NF+f], fn_lpm[t*NF+f]};
  endfunction

  function automatic logic [7:0] byte_of(int t);
    return exp_cfg[t/4][(t%4)*8 +: 8];
  endfunction

  task automatic check_pads(input string req);
    for (int t = 0; t < NT; t++)
      check(req, {28'd0, pad_dout[t], pad_oe[t], pad_sben[t], pad_lpm[t]},
            {28'd0, exp_pad(t, byte_of(t))});
  endtask

  task automatic shuffle_fn();
    fn_dout = NS'($urandom); fn_oe = NS'($urandom);
    fn_sben = NS'($urandom); fn_lpm = NS'($urandom);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nbad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] old_word;
    for (int r = 0; r < NREG; r++) begin
      exp_cfg[r] = '0;
      for (int b = 0; b < 4; b++) if (r*4+b < NT) exp_cfg[r][b*8] = 1'b1;
    end
    shuffle_fn();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); @(negedge clk);

    // R3: reset contents, status and default routing
    for (int r = 0; r < NREG; r++) begin rd(r, d); check("R3 reset word", d, exp_cfg[r]); end
    rd(14, d); check("R3 reset status", d, 32'd0);
    check_pads("R3 default pads");

    // R8: locked write rejected
    wr(0, 32'h0202_0202, 1'b1);
    rd(0, d); check("R8 locked write ignored", d, exp_cfg[0]);
    rd(14, d); check("R8 locked write flags", d, 32'd1);
    // R9: writing 0 keeps flag, writing 1 clears
    wr(14, 32'd0, 1'b1);
    rd(14, d); check("R9 write 0 keeps flag", d, 32'd1);
    wr(14, 32'd1, 1'b1);
    rd(14, d); check("R9 write 1 clears", d, 32'd0);

    // R7: unprivileged key writes do nothing except flag
    wr(12, K0, 1'b0); wr(13, K1, 1'b0);
    rd(14, d); check("R7 unpriv kick rejected", d, 32'd1);
    // overlap: second rejected write while flag already set
    wr(14, 32'd1, 1'b0);
    rd(14, d); check("R7 unpriv clear rejected", d, 32'd1);
    wr(14, 32'd1, 1'b1);

    // R8: wrong order stays locked, right order unlocks
    wr(13, K1, 1'b1); wr(12, K0, 1'b1);
    rd(14, d); check("R8 half sequence locked", d, 32'd0);
    wr(12, K0, 1'b1); wr(13, K1, 1'b1);
    rd(14, d); check("R8 unlocked", d, 32'd2);

    // R10: key registers and unmapped addresses
    rd(12, d); check("R10 kick0 reads 0", d, 32'd0);
    rd(13, d); check("R10 kick1 reads 0", d, 32'd0);
    rd(5, d);  check("R10 unmapped reads 0", d, 32'd0);
    wr(7, 32'hFFFF_FFFF, 1'b1);
    rd(14, d); check("R10 unmapped write no flag", d, 32'd2);

    // R5: reserved bits and missing terminals
    wr(1, 32'hFFFF_FFFF, 1'b1);
    exp_cfg[1] = 32'hFFFF_FFFF & lane_mask(1);
    rd(1, d); check("R5 reserved masked", d, 32'h0000_0F0F);

    // R1 R2 R4 R5 R6 R7: full sweep of every byte value on every terminal
    for (int t = 0; t < NT; t++) begin
      for (int v = 0; v < 256; v++) begin
        logic [31:0] w;
        shuffle_fn();
        w = exp_cfg[t/4];
        w[(t%4)*8 +: 8] = 8'(v);
        if (v % 37 == 5) begin
          wr(t/4, ~w, 1'b0);
          rd(t/4, d); check("R7 unpriv write ignored", d, exp_cfg[t/4]);
          wr(14, 32'd1, 1'b1);
        end
        wr(t/4, w, 1'b1);
        exp_cfg[t/4] = w & lane_mask(t/4);
        rd(t/4, d); check("R1 R5 R6 readback", d, exp_cfg[t/4]);
        check_pads("R2 R4 routing");
      end
    end

    // R2: selection change and input change in the same cycle
    wr(0, 32'h0101_0101, 1'b1);
    exp_cfg[0] = 32'h0101_0101;
    @(negedge clk);
    shuffle_fn();
    old_word = exp_cfg[0];
    wr(0, 32'h0804_0402, 1'b1);
    check_pads("R2 old selection new inputs");
    exp_cfg[0] = 32'h0804_0402;
    @(posedge clk); @(negedge clk);
    check_pads("R2 new selection");
    check("R2 word changed", exp_cfg[0] ^ old_word, 32'h0905_0503);

    // R8: wrong key relocks, then selection writes bounce
    wr(12, 32'h1234_5678, 1'b1);
    rd(14, d); check("R8 relocked", d, 32'd0);
    wr(0, 32'h0101_0101, 1'b1);
    rd(0, d); check("R8 relocked write ignored", d, exp_cfg[0]);
    rd(14, d); check("R8 relocked flag", d, 32'd1);

    finish_run();
  end

endmodule